// File: doc/BRIEF.md
# Address-Masked Eight-Pin GPIO Port

This block is an eight-pin general-purpose I/O port attached to an APB slave port. Each pin is either driven by the block or sampled from the pad, as chosen by a per-pin direction register. The output value and output-enable buses go to the pad ring, and the raw pad levels come back on an input bus.

The data register is reached through a 1 KiB address window. Address bits [9:2] of each data access act as a per-pin mask (pin n uses address bit n+2). A masked write changes only the selected pins. A masked read returns zero on every unselected pin. Software can therefore set, clear or test single pins with one bus transfer and no read-modify-write. Pad inputs pass through a two-flop synchroniser before reads can see them.

Top module: `apb_masked_gpio`

## Requirements
- R1: After reset the direction register and the output data register are zero, so pinOe and pinOut are 8'h00 and all pins are inputs.
- R2: A read at offset 0x000 to 0x3FC returns, for pin n, its read source when address bit n+2 is 1, and 0 when that bit is 0.
- R3: A write at offset 0x000 to 0x3FC loads pwdata bit n into output bit n for every pin n whose address bit n+2 is 1.
- R4: During such a write, output bits whose address bit n+2 is 0 keep their previous value.
- R5: The direction register at offset 0x400 is readable and writable; bit n = 1 makes pin n an output, 0 an input, and pinOe equals the register.
- R6: The read source of a pin is its stored output bit when the pin is an output and its synchronised pad level when the pin is an input; pinOut always equals the stored output register.
- R7: A pad level change is not visible to reads one clock edge after it is sampled and is visible after two edges.
- R8: Reads of any offset other than the data window and 0x400 return 8'h00, and writes to them change no register.
- R9: Every transfer finishes with no wait state: pready is 1 and pslverr is 0 in the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| padIn | input | 8 | Raw pad levels |
| pinOut | output | 8 | Output value to the pads |
| pinOe | output | 8 | Per-pin output enable |

## Verification
The bench goes after the mask mapping. It uses single-bit masks at both ends (address bit 2 and bit 9), a zero mask and a full mask. A design that shifted the mask by one pin, or took it from the wrong address bits, would return or change the wrong pin. Mixed direction settings check that output pins read their driven value and input pins read the pad; a swapped read source would return pad bits where driven bits are expected. A read made one edge after a pad change must still show the old level; a single-flop synchroniser would show the new one. Writes just past the direction register and reads above the window check that loose decoding does not alias onto live registers.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  // Strobes from the bus control to the datapath, valid for one access.
  typedef struct packed {
    logic dataWr;
    logic dataRd;
    logic dirWr;
    logic dirRd;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int DIR_OFFS  = 'h400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  output gpioStrobe_t          strb,
  output logic [PIN_COUNT-1:0] mask
);
  // Data window spans one word per mask value.
  localparam logic [ADDR_W-1:0] DATA_END = ADDR_W'(4 << PIN_COUNT);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFS);

  logic dataHit;
  logic dirHit;
  logic accessWr;
  logic anyRd;

  assign dataHit  = paddr < DATA_END;
  assign dirHit   = paddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2];
  assign accessWr = psel && penable && pwrite;
  assign anyRd    = psel && !pwrite;

  // Mask bit n comes from address bit n+2.
  assign mask = paddr[PIN_COUNT+1:2];

  always_comb begin
    strb        = '0;
    strb.dataWr = accessWr && dataHit;
    strb.dirWr  = accessWr && dirHit;
    strb.dataRd = anyRd && dataHit;
    strb.dirRd  = anyRd && dirHit;
  end

  // R8: at most one register is touched per cycle.
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dataWr, strb.dirWr, strb.dataRd, strb.dirRd}));

  // R8: a write far above the data window and direction word never strobes.
  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accessWr && paddr[ADDR_W-1:PIN_COUNT+3] != '0) |-> !(strb.dataWr || strb.dirWr));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= rawIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_mask_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strb,
  input  logic [PIN_COUNT-1:0] mask,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] padSync;
  logic [PIN_COUNT-1:0] readSrc;

  gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_DEPTH)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  (padIn),
    .syncOut(padSync)
  );

  // Per-pin storage and read source selection.
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg[i] <= 1'b0;
        dirReg[i] <= 1'b0;
      end else begin
        if (strb.dataWr && mask[i]) outReg[i] <= wrData[i];
        if (strb.dirWr)             dirReg[i] <= wrData[i];
      end
    end
    assign readSrc[i] = dirReg[i] ? outReg[i] : padSync[i];
  end

  always_comb begin
    rdData = '0;
    if (strb.dataRd)     rdData = readSrc & mask;
    else if (strb.dirRd) rdData = dirReg;
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;

  // R3: selected pins take the written value.
  p_masked_take_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> ((pinOut ^ $past(wrData)) & $past(mask)) == '0);

  // R4: unselected pins keep their value across a data write.
  p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> ((pinOut ^ $past(pinOut)) & ~$past(mask)) == '0);

  // R5: output enables follow a direction write.
  p_oe_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> pinOe == $past(wrData));

  // R8: without a write strobe no register moves.
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.dataWr || strb.dirWr) |=> ($stable(pinOut) && $stable(pinOe)));

  // R2: unmasked pins read as zero.
  p_read_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataRd |-> (rdData & ~mask) == '0);
endmodule

// File: rtl/apb_masked_gpio.sv
module apb_masked_gpio
  import gpio_mask_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFS   = 'h400,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [PIN_COUNT-1:0] pwdata,
  output logic [PIN_COUNT-1:0] prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  gpioStrobe_t          strb;
  logic [PIN_COUNT-1:0] mask;

  gpio_bus_ctrl #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .DIR_OFFS(DIR_OFFS)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .strb   (strb),
    .mask   (mask)
  );

  gpio_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_DEPTH(SYNC_DEPTH)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .mask  (mask),
    .wrData(pwdata),
    .padIn (padIn),
    .rdData(prdata),
    .pinOut(pinOut),
    .pinOe (pinOe)
  );

  // R9: zero-wait, never an error.
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: tb/test_apb_masked_gpio.sv
module test_apb_masked_gpio;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, prdata, padIn = 8'hA5, pinOut, pinOe;
  logic       pready, pslverr;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  apb_masked_gpio i_apb_masked_gpio (
    .clk, .rstN, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pslverr, .padIn, .pinOut, .pinOe
  );

  // {req[3:0], write, addr[11:0], wdata[7:0], expected read[7:0]}; pads = A5.
  localparam int NV = 18;
  localparam logic [32:0] VEC [NV] = '{
    {4'd2, 1'b0, 12'h3FC, 8'h00, 8'hA5},  // R2 full mask, all inputs
    {4'd2, 1'b0, 12'h004, 8'h00, 8'h01},  // R2 mask pin0
    {4'd2, 1'b0, 12'h008, 8'h00, 8'h00},  // R2 mask pin1, pad low
    {4'd5, 1'b1, 12'h400, 8'h0F, 8'h00},  // R5 low nibble outputs
    {4'd3, 1'b1, 12'h3FC, 8'h3C, 8'h00},  // R3 full write
    {4'd6, 1'b0, 12'h3FC, 8'h00, 8'hAC},  // R6 mixed sources
    {4'd4, 1'b1, 12'h00C, 8'hFF, 8'h00},  // R4 only pins 0,1 change
    {4'd4, 1'b0, 12'h03C, 8'h00, 8'h0F},  // R4 read low nibble
    {4'd4, 1'b1, 12'h000, 8'h00, 8'h00},  // R4 zero mask write
    {4'd4, 1'b0, 12'h3FC, 8'h00, 8'hAF},  // R4 nothing changed
    {4'd5, 1'b0, 12'h400, 8'h00, 8'h0F},  // R5 read back
    {4'd8, 1'b1, 12'h404, 8'hFF, 8'h00},  // R8 stray write
    {4'd8, 1'b0, 12'h400, 8'h00, 8'h0F},  // R8 direction untouched
    {4'd8, 1'b0, 12'h800, 8'h00, 8'h00},  // R8 outside read
    {4'd8, 1'b0, 12'hFFC, 8'h00, 8'h00},  // R8 outside read
    {4'd3, 1'b1, 12'h200, 8'h80, 8'h00},  // R3 mask pin7 only
    {4'd5, 1'b1, 12'h400, 8'hFF, 8'h00},  // R5 all outputs
    {4'd6, 1'b0, 12'h3FC, 8'h00, 8'hBF}   // R6 all driven values
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apbXfer(input logic wr, input logic [11:0] addr,
                         input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata;
    check("R9 pready", {7'd0, pready}, 8'h01);
    check("R9 pslverr", {7'd0, pslverr}, 8'h00);
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      apbXfer(VEC[v][28], VEC[v][27:16], VEC[v][15:8], rd);
      if (!VEC[v][28])
        check($sformatf("R%0d vector %0d", VEC[v][32:29], v), rd, VEC[v][7:0]);
    end
    check("R5 pinOe", pinOe, 8'hFF);
    check("R6 pinOut", pinOut, 8'hBF);

    // R7: switch back to inputs, then change pad and read one edge later.
    apbXfer(1'b1, 12'h400, 8'h00, rd);
    repeat (3) @(negedge clk);
    @(negedge clk);
    padIn = 8'h5A;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h3FC;
    @(negedge clk);               // one edge since pad change
    penable = 1'b1;
    #1;
    check("R7 one edge old value", prdata, 8'hA5);
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
    apbXfer(1'b0, 12'h3FC, 8'h00, rd);
    check("R7 settled new value", rd, 8'h5A);
    // R2: highest mask bit alone
    apbXfer(1'b0, 12'h200, 8'h00, rd);
    check("R2 mask pin7", rd, 8'h00);
    apbXfer(1'b0, 12'h100, 8'h00, rd);
    check("R2 mask pin6", rd, 8'h40);
    // R6: pinOut keeps stored value while pins are inputs
    check("R6 pinOut held", pinOut, 8'hBF);
    check("R5 pinOe cleared", pinOe, 8'h00);

    // R1: reset in mid-run clears registers
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 re-reset pinOut", pinOut, 8'h00);
    check("R1 re-reset pinOe", pinOe, 8'h00);
    finishRun();
  end
endmodule